// File: doc/BRIEF.md
# PHY PLL Programming Sequencer

This block drives the fixed series of PHY register writes that sets up a high-speed serial PHY's PLL. A one-cycle `start` captures the requested lane rate in Mbps, the input divider N, the feedback multiplier M and three analog selections: charge-pump current, loop-filter resistance and receive frequency band. The block then emits twelve register writes, one at a time. Each write is an 8-bit register code and an 8-bit data byte, sent to a downstream test-port write engine.

The block derives two kinds of field itself. The first is the VCO range field, computed from the lane rate. The second is the divider encodings, each of which is the value minus one. The 9-bit feedback encoding does not fit in one register, so it goes out as a low half and a high half through the same register. Each half is followed at once by a write to the divider-control register, which commits it. Without that commit straight after the low half, the low bits do not take effect.

The write interface is valid/ready, with completion reported separately. While `wr_valid` is high and `wr_ready` is low, the code and data hold steady, so the sink may stall for any number of cycles. The transfer happens on the cycle where both are high. After that the block drops `wr_valid` and waits for a one-cycle `wr_cmpl` before it offers the next write. `busy` stays high from the cycle after a start until the last completion. `done` pulses for one cycle when `busy` falls.

Top module: `phy_pll_prog_seq`

## Requirements
- R1: After reset `busy`, `done` and `wr_valid` are low.
- R2: A `start` seen while idle latches all inputs. On the next cycle `busy` is high and the first write is offered on `wr_valid`.
- R3: Register codes are issued in exactly this order (hex): 10, 11, 12, 44, 17, 18, 19, 18, 19, 22, 22, 20.
- R4: Data for code 10 has bit 7 set, bit 6 clear, the VCO range in bits [5:3], bits [2:1] = 01 and bit 0 set. The VCO range is 0 for a rate below 200. Otherwise it is the low 3 bits of (rate + 100) / 200, using integer division.
- R5: Data for code 11 carries the charge-pump select in bits [3:0], with the upper bits zero. Data for code 12 has bits 7 and 6 set and the loop-filter select in bits [5:0]. Data for code 44 carries the frequency band in bits [6:1], with bits 7 and 0 zero.
- R6: Data for code 17 is (N - 1) masked to 7 bits, with bit 7 zero.
- R7: The first code-18 write carries (M - 1) bits [4:0] with bits [7:5] zero. The second code-18 write carries (M - 1) bits [8:5] in bits [3:0], with bit 7 set and bits [6:4] zero. Each code-18 write is followed directly by code 19 with data 30 hex.
- R8: Code 22 is written first with data 07 hex and then with 87 hex. The last write is code 20 with data 4D hex.
- R9: While `wr_valid` is high and `wr_ready` is low, the code and data hold. After a transfer, `wr_valid` stays low until `wr_cmpl` is seen. Only then is the next write offered.
- R10: In the cycle after the completion of the last write, `done` is high for exactly one cycle and `busy` is low.
- R11: While busy, a new `start` and changes on the configuration inputs have no effect on the writes in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a programming run (honoured only when idle) |
| lane_rate | input | RATE_W | Lane rate in Mbps |
| in_div | input | NDIV_W | PLL input divider N |
| fb_mult | input | MDIV_W | PLL feedback multiplier M |
| cp_sel | input | 4 | Charge-pump current selection |
| lpf_sel | input | 6 | Loop-filter resistance selection |
| hs_range | input | 6 | Receive frequency band selection |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| wr_valid | output | 1 | Register write offered |
| wr_ready | input | 1 | Write engine accepts the offered write |
| wr_code | output | 8 | Register code of the offered write |
| wr_data | output | 8 | Data byte of the offered write |
| wr_cmpl | input | 1 | Write engine finished the accepted write |

## Verification
The assertions rely on the write engine following the handshake:
- It raises `wr_cmpl` only while a write is outstanding, that is, after a transfer and before the next offer.
- It pulses `wr_cmpl` once per write.

The bench keeps to this. It raises `wr_cmpl` only after it has seen `wr_valid` fall following its own `wr_ready`. It stalls both the acceptance and the completion by chosen numbers of cycles, and it never asserts `wr_ready` without a pending offer.

// File: rtl/pllseq_pkg.sv
package pllseq_pkg;
  localparam int NUM_STEPS = 12;
  localparam int STEP_W    = $clog2(NUM_STEPS);
  localparam int CODE_W    = 8;
  localparam int DATA_W    = 8;
  localparam int VCO_W     = 3;
  localparam int CP_W      = 4;
  localparam int LPF_W     = 6;
  localparam int HSR_W     = 6;
  localparam int NENC_W    = 7;
  localparam int MENC_W    = 9;
  localparam int MLO_W     = 5;

  localparam logic [CODE_W-1:0] A_VCO    = 8'h10;
  localparam logic [CODE_W-1:0] A_CPUMP  = 8'h11;
  localparam logic [CODE_W-1:0] A_FILT   = 8'h12;
  localparam logic [CODE_W-1:0] A_BAND   = 8'h44;
  localparam logic [CODE_W-1:0] A_NDIV   = 8'h17;
  localparam logic [CODE_W-1:0] A_MDIV   = 8'h18;
  localparam logic [CODE_W-1:0] A_DIVCTL = 8'h19;
  localparam logic [CODE_W-1:0] A_ANALOG = 8'h22;
  localparam logic [CODE_W-1:0] A_POWER  = 8'h20;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic [VCO_W-1:0]  vco;
    logic [CP_W-1:0]   cp;
    logic [LPF_W-1:0]  lpf;
    logic [HSR_W-1:0]  band;
    logic [NENC_W-1:0] nenc;
    logic [MENC_W-1:0] menc;
  } pll_cfg_t;
endpackage

// File: rtl/pllseq_vco_enc.sv
module pllseq_vco_enc
  import pllseq_pkg::*;
#(
  parameter int RATE_W = 11
) (
  input  logic [RATE_W-1:0] rate,
  output logic [VCO_W-1:0]  vco
);
  localparam logic [RATE_W:0] BAND_STEP = (RATE_W+1)'(200);
  localparam logic [RATE_W:0] ROUND_ADD = (RATE_W+1)'(100);

  logic [RATE_W:0] biased;
  logic [RATE_W:0] quot;

  always_comb begin
    biased = {1'b0, rate} + ROUND_ADD;
    quot   = biased / BAND_STEP;
    if ({1'b0, rate} < BAND_STEP) vco = '0;
    else                          vco = quot[VCO_W-1:0];
  end
endmodule

// File: rtl/pllseq_step_rom.sv
module pllseq_step_rom
  import pllseq_pkg::*;
(
  input  logic [STEP_W-1:0] idx,
  input  pll_cfg_t          cfg,
  output logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data
);
  always_comb begin
    code = A_POWER;
    data = 8'h4D;
    unique case (idx)
      4'd0:  begin code = A_VCO;    data = {2'b10, cfg.vco, 3'b011}; end
      4'd1:  begin code = A_CPUMP;  data = {4'h0, cfg.cp}; end
      4'd2:  begin code = A_FILT;   data = {2'b11, cfg.lpf}; end
      4'd3:  begin code = A_BAND;   data = {1'b0, cfg.band, 1'b0}; end
      4'd4:  begin code = A_NDIV;   data = {1'b0, cfg.nenc}; end
      4'd5:  begin code = A_MDIV;   data = {3'b000, cfg.menc[MLO_W-1:0]}; end
      4'd6:  begin code = A_DIVCTL; data = 8'h30; end
      4'd7:  begin code = A_MDIV;   data = {4'h8, cfg.menc[MENC_W-1:MLO_W]}; end
      4'd8:  begin code = A_DIVCTL; data = 8'h30; end
      4'd9:  begin code = A_ANALOG; data = 8'h07; end
      4'd10: begin code = A_ANALOG; data = 8'h87; end
      default: begin code = A_POWER; data = 8'h4D; end
    endcase
  end
endmodule

// File: rtl/pllseq_ctrl.sv
module pllseq_ctrl
  import pllseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              wr_ready,
  input  logic              wr_cmpl,
  output logic              wr_valid,
  output logic              busy,
  output logic              done,
  output logic              load,
  output logic [STEP_W-1:0] idx
);
  localparam logic [STEP_W-1:0] LAST_IDX = STEP_W'(NUM_STEPS - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] idx_d;
  logic              done_d;

  always_comb begin
    state_d = state_q;
    idx_d   = idx;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_d = ST_OFFER;
          idx_d   = '0;
        end
      end
      ST_OFFER: begin
        if (wr_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (wr_cmpl) begin
          if (idx == LAST_IDX) begin
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            state_d = ST_OFFER;
            idx_d   = idx + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx     <= '0;
      done    <= 1'b0;
    end else begin
      state_q <= state_d;
      idx     <= idx_d;
      done    <= done_d;
    end
  end

  assign load     = (state_q == ST_IDLE) && start;
  assign busy     = (state_q != ST_IDLE);
  assign wr_valid = (state_q == ST_OFFER);
endmodule

// File: rtl/phy_pll_prog_seq.sv
module phy_pll_prog_seq
  import pllseq_pkg::*;
#(
  parameter int RATE_W = 11,
  parameter int NDIV_W = 8,
  parameter int MDIV_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [RATE_W-1:0] lane_rate,
  input  logic [NDIV_W-1:0] in_div,
  input  logic [MDIV_W-1:0] fb_mult,
  input  logic [CP_W-1:0]   cp_sel,
  input  logic [LPF_W-1:0]  lpf_sel,
  input  logic [HSR_W-1:0]  hs_range,
  output logic              busy,
  output logic              done,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [CODE_W-1:0] wr_code,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_cmpl
);
  logic              load;
  logic [STEP_W-1:0] idx;
  logic [VCO_W-1:0]  vco_w;
  logic [NDIV_W-1:0] n_minus1;
  logic [MDIV_W-1:0] m_minus1;
  pll_cfg_t          cfg_q;

  assign n_minus1 = in_div - NDIV_W'(1);
  assign m_minus1 = fb_mult - MDIV_W'(1);

  pllseq_vco_enc #(.RATE_W(RATE_W)) u_vco (
    .rate (lane_rate),
    .vco  (vco_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (load) begin
      cfg_q.vco  <= vco_w;
      cfg_q.cp   <= cp_sel;
      cfg_q.lpf  <= lpf_sel;
      cfg_q.band <= hs_range;
      cfg_q.nenc <= n_minus1[NENC_W-1:0];
      cfg_q.menc <= m_minus1[MENC_W-1:0];
    end
  end

  pllseq_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .wr_ready (wr_ready),
    .wr_cmpl  (wr_cmpl),
    .wr_valid (wr_valid),
    .busy     (busy),
    .done     (done),
    .load     (load),
    .idx      (idx)
  );

  pllseq_step_rom u_rom (
    .idx  (idx),
    .cfg  (cfg_q),
    .code (wr_code),
    .data (wr_data)
  );
endmodule

// File: rtl/phy_pll_prog_seq_chk.sv
module phy_pll_prog_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic       busy,
  input logic       done,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic [7:0] wr_code,
  input logic [7:0] wr_data
);
  AST_PAYLOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_code) && $stable(wr_data)); // R9
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_valid); // R9
  AST_IDLE_NO_OFFER: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !wr_valid); // R2
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy && wr_valid); // R2
  AST_FIRST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wr_code == 8'h10); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R10
  AST_LAST_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_code) == 8'h20 && $past(wr_data) == 8'h4D); // R8
endmodule

bind phy_pll_prog_seq phy_pll_prog_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .wr_valid (wr_valid),
  .wr_ready (wr_ready),
  .wr_code  (wr_code),
  .wr_data  (wr_data)
);

// File: tb/phy_pll_prog_seq_tb.sv
module phy_pll_prog_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [10:0] lane_rate = '0;
  logic [7:0]  in_div = 8'd1;
  logic [9:0]  fb_mult = 10'd1;
  logic [3:0]  cp_sel = '0;
  logic [5:0]  lpf_sel = '0;
  logic [5:0]  hs_range = '0;
  logic        busy, done, wr_valid;
  logic        wr_ready = 1'b0;
  logic        wr_cmpl = 1'b0;
  logic [7:0]  wr_code, wr_data;

  int vectors = 0;
  int miscompares = 0;

  always #4 clk = ~clk;

  phy_pll_prog_seq u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_rate(lane_rate),
    .in_div(in_div), .fb_mult(fb_mult), .cp_sel(cp_sel), .lpf_sel(lpf_sel),
    .hs_range(hs_range), .busy(busy), .done(done), .wr_valid(wr_valid),
    .wr_ready(wr_ready), .wr_code(wr_code), .wr_data(wr_data), .wr_cmpl(wr_cmpl)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  function automatic logic [7:0] exp_code(input int i);
    case (i)
      0: return 8'h10;  1: return 8'h11;  2: return 8'h12;  3: return 8'h44;
      4: return 8'h17;  5: return 8'h18;  6: return 8'h19;  7: return 8'h18;
      8: return 8'h19;  9: return 8'h22; 10: return 8'h22;  default: return 8'h20;
    endcase
  endfunction

  function automatic string req_of(input int i);
    case (i)
      0: return "R4";
      1, 2, 3: return "R5";
      4: return "R6";
      5, 6, 7, 8: return "R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [7:0] exp_data(input int i, input int rate, input int n,
      input int m, input int cp, input int lpf, input int fr);
    int vco;
    int nm1;
    int mm1;
    vco = (rate < 200) ? 0 : ((rate + 100) / 200) % 8;
    nm1 = (n - 1) & 8'hFF;
    mm1 = (m - 1) & 10'h3FF;
    case (i)
      0:  return 8'(8'h80 | (vco << 3) | 8'h03);
      1:  return 8'(cp & 15);
      2:  return 8'(8'hC0 | (lpf & 63));
      3:  return 8'((fr & 63) << 1);
      4:  return 8'(nm1 & 127);
      5:  return 8'(mm1 & 31);
      6:  return 8'h30;
      7:  return 8'(8'h80 | ((mm1 >> 5) & 15));
      8:  return 8'h30;
      9:  return 8'h07;
      10: return 8'h87;
      default: return 8'h4D;
    endcase
  endfunction

  // Runs one full programming sequence and checks every write.
  task automatic run_seq(input int rate, input int n, input int m, input int cp,
      input int lpf, input int fr, input int rdly, input int cdly, input bit perturb);
    @(negedge clk);
    lane_rate = 11'(rate); in_div = 8'(n); fb_mult = 10'(m);
    cp_sel = 4'(cp); lpf_sel = 6'(lpf); hs_range = 6'(fr);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && wr_valid, "R2", "busy/valid after start", {busy, wr_valid}, 3);
    if (perturb) begin
      lane_rate = 11'd1234; in_div = 8'd77; fb_mult = 10'd301;
      cp_sel = 4'hF; lpf_sel = 6'h3F; hs_range = 6'h2A;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 12; i++) begin
      logic [7:0] c0, d0;
      int guard;
      guard = 0;
      while (!wr_valid && guard < 50) begin @(negedge clk); guard++; end
      chk(wr_valid, "R9", "offer present", wr_valid, 1);
      c0 = wr_code; d0 = wr_data;
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        chk(wr_valid && wr_code == c0 && wr_data == d0, "R9", "hold under stall",
            {wr_code, wr_data}, {c0, d0});
      end
      chk(wr_code == exp_code(i), "R3", $sformatf("code of write %0d", i),
          wr_code, exp_code(i));
      chk(wr_data == exp_data(i, rate, n, m, cp, lpf, fr), req_of(i),
          $sformatf("data of write %0d", i), wr_data,
          exp_data(i, rate, n, m, cp, lpf, fr));
      wr_ready = 1'b1;
      @(negedge clk);
      wr_ready = 1'b0;
      chk(!wr_valid, "R9", "offer drops after transfer", wr_valid, 0);
      for (int k = 0; k < cdly; k++) begin
        @(negedge clk);
        chk(!wr_valid, "R9", "no offer before completion", wr_valid, 0);
      end
      wr_cmpl = 1'b1;
      @(negedge clk);
      wr_cmpl = 1'b0;
      if (i == 11) begin
        chk(done && !busy, "R10", "done/busy after last", {done, busy}, 2);
        @(negedge clk);
        chk(!done, "R10", "done single pulse", done, 0);
      end else begin
        chk(!done && busy, "R10", "no early done", {done, busy}, 1);
      end
    end
  endtask

  task automatic t_reset();
    chk(!busy && !done && !wr_valid, "R1", "reset outputs", {busy, done, wr_valid}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !wr_valid, "R1", "idle after release", {busy, done, wr_valid}, 0);
  endtask

  task automatic t_low_rate();
    run_seq(150, 3, 40, 1, 2, 1, 0, 0, 1'b0);
  endtask

  task automatic t_vco_edges();
    run_seq(199, 2, 20, 9, 4, 16, 0, 0, 1'b0);
    run_seq(200, 2, 20, 9, 4, 16, 0, 1, 1'b0);
    run_seq(899, 4, 100, 6, 8, 57, 1, 0, 1'b0);
    run_seq(1000, 5, 200, 11, 16, 26, 0, 0, 1'b0);
    run_seq(1500, 6, 300, 11, 8, 60, 0, 0, 1'b0);
  endtask

  task automatic t_div_extremes();
    run_seq(600, 1, 512, 6, 8, 23, 0, 0, 1'b0);
    run_seq(400, 129, 6, 1, 1, 37, 0, 0, 1'b0);
  endtask

  task automatic t_backpressure();
    run_seq(700, 7, 66, 6, 4, 24, 3, 4, 1'b0);
  endtask

  task automatic t_busy_ignore();
    // R11: start and config changes during busy must not alter the run
    run_seq(250, 3, 90, 2, 1, 35, 2, 1, 1'b1);
  endtask

  initial begin
    t_reset();
    t_low_rate();
    t_vco_edges();
    t_div_extremes();
    t_backpressure();
    t_busy_ignore();
    repeat (3) @(negedge clk);
    chk(!busy && !wr_valid, "R11", "idle after perturbed run", {busy, wr_valid}, 0);
    finish_run();
  end
endmodule